// File: doc/BRIEF.md
# Special Function Register Bank with Byte-Clearing Writes

This block holds one 512-byte control-register area as 256 words of 16 bits. A single request port carries an operation code, a word address, a byte-lane select, write data and a bit index. Full-word writes store all 16 bits. A single-byte write stores the addressed byte and forces the other byte of the same word to zero. It never merges with the old contents.

Bit-level operations are single-bit set, single-bit clear, and a masked field update on either byte. They are accepted only in the bit-addressable zone, which is words 128 to 239: the upper half of the area without its 16 highest words. A bit operation aimed at any other word is rejected. The word keeps its value, and `bit_err` is raised during the request cycle.

Reads are combinational from `req_addr`. All updates land on the rising clock edge. There is no state machine. The operation decoder classifies each request into one of three actions, applied on the edge: IDLE (no change), STORE (the computed word is written), or REJECT (nothing is written, and the error is flagged). STORE arises from a write with a non-zero lane select, or from a bit operation inside the zone. REJECT arises only from a bit operation outside the zone.

Top module: `sfr_bank`

## Requirements
- R1: After the asynchronous active-low reset, every word reads as 0x0000.
- R2: `rd_data` always equals the current contents of the word at `req_addr`, in the same cycle and with no clock.
- R3: Operation code 1 (write) with `req_lanes` = 2'b11 stores `req_wdata` in the addressed word on the next rising edge.
- R4: A write with `req_lanes` = 2'b01 stores `req_wdata[7:0]` in the low byte and clears the high byte.
- R5: A write with `req_lanes` = 2'b10 stores `req_wdata[15:8]` in the high byte and clears the low byte.
- R6: These requests change no word and keep `bit_err` low: a write with `req_lanes` = 2'b00, operation code 0 (idle), and the reserved codes 6 and 7.
- R7: Operation code 2 (bit set) on a word in 128..239 sets bit `req_bit` and leaves the other bits unchanged.
- R8: Operation code 3 (bit clear) on a word in 128..239 clears bit `req_bit` and leaves the other bits unchanged.
- R9: Operation code 4 (low field) on a word in 128..239 makes the low byte (low & ~M) | (D & M), where M = `req_wdata[15:8]` and D = `req_wdata[7:0]`. The high byte is unchanged.
- R10: Operation code 5 (high field) on a word in 128..239 applies the same masked merge, with the same M and D, to the high byte. The low byte is unchanged.
- R11: A bit operation (codes 2 to 5) on a word in 0..127 or 240..255 changes no word, and `bit_err` is high in the request cycle.
- R12: `bit_err` is low for writes, for idle and reserved codes, and for bit operations inside 128..239.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_op | input | 3 | Operation: 0 idle, 1 write, 2 bit set, 3 bit clear, 4 low field, 5 high field, 6/7 reserved |
| req_lanes | input | 2 | Byte-lane select for writes: bit 0 low byte, bit 1 high byte |
| req_addr | input | 8 | Word address for the request and the read |
| req_wdata | input | 16 | Write data; for field operations, mask in [15:8] and data in [7:0] |
| req_bit | input | 4 | Bit index for set and clear |
| rd_data | output | 16 | Contents of the word at `req_addr` |
| bit_err | output | 1 | Bit operation aimed outside words 128..239 |

## Verification
The hardest situation to reach is a rejected bit operation on a word that already holds a distinctive non-zero value. Only then does an accidental store show up as a changed word, rather than one that still reads zero. The stimulus therefore first writes known patterns with full-word writes to the words just outside each edge of the zone: 127, 240 and 255. It then aims set, clear and field operations at them and reads them back.

The same boundary-first approach covers the edges of the zone itself, 128 and 239. It is also used for byte writes, which are applied to a word that holds bits in both bytes, so that the cleared byte is observable.

// File: rtl/sfr_bank_pkg.sv
`timescale 1ns/1ps
package sfr_bank_pkg;
    typedef enum logic [2:0] {
        OP_IDLE  = 3'd0,
        OP_WRITE = 3'd1,
        OP_BSET  = 3'd2,
        OP_BCLR  = 3'd3,
        OP_FLDLO = 3'd4,
        OP_FLDHI = 3'd5,
        OP_RSV6  = 3'd6,
        OP_RSV7  = 3'd7
    } sfr_op_e;

    typedef enum logic [1:0] {
        ACT_IDLE   = 2'd0,
        ACT_STORE  = 2'd1,
        ACT_REJECT = 2'd2
    } sfr_act_e;
endpackage

// File: rtl/sfr_zone_check.sv
`timescale 1ns/1ps
module sfr_zone_check #(
    parameter int unsigned ADDR_W  = 8,
    parameter int unsigned ZONE_LO = 128,
    parameter int unsigned ZONE_HI = 239
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              in_zone
);
    localparam logic [ADDR_W-1:0] LO_A = ADDR_W'(ZONE_LO);
    localparam logic [ADDR_W-1:0] HI_A = ADDR_W'(ZONE_HI);

    always_comb begin
        in_zone = (addr >= LO_A) && (addr <= HI_A);
    end
endmodule

// File: rtl/sfr_op_unit.sv
`timescale 1ns/1ps
module sfr_op_unit
    import sfr_bank_pkg::*;
#(
    parameter int unsigned WORD_W = 16,
    parameter int unsigned IDX_W  = $clog2(WORD_W)
) (
    input  sfr_op_e           op,
    input  logic [1:0]        lanes,
    input  logic [WORD_W-1:0] wdata,
    input  logic [IDX_W-1:0]  bit_idx,
    input  logic [WORD_W-1:0] cur_word,
    input  logic              in_zone,
    output logic [WORD_W-1:0] new_word,
    output sfr_act_e          action
);
    localparam int unsigned      BYTE_W = WORD_W / 2;
    localparam logic [WORD_W-1:0] ONE   = WORD_W'(1);
    localparam logic [BYTE_W-1:0] ZB    = '0;

    logic [BYTE_W-1:0] cur_lo, cur_hi, f_mask, f_data, w_lo, w_hi;
    logic [WORD_W-1:0] bit_sel;

    always_comb begin
        cur_lo  = cur_word[BYTE_W-1:0];
        cur_hi  = cur_word[WORD_W-1:BYTE_W];
        w_lo    = wdata[BYTE_W-1:0];
        w_hi    = wdata[WORD_W-1:BYTE_W];
        f_mask  = w_hi;
        f_data  = w_lo;
        bit_sel = ONE << bit_idx;
    end

    // Next-word datapath
    always_comb begin
        new_word = cur_word;
        unique case (op)
            OP_WRITE: begin
                unique case (lanes)
                    2'b11:   new_word = wdata;
                    2'b01:   new_word = {ZB, w_lo};
                    2'b10:   new_word = {w_hi, ZB};
                    default: new_word = cur_word;
                endcase
            end
            OP_BSET:  new_word = cur_word | bit_sel;
            OP_BCLR:  new_word = cur_word & ~bit_sel;
            OP_FLDLO: new_word = {cur_hi, (cur_lo & ~f_mask) | (f_data & f_mask)};
            OP_FLDHI: new_word = {(cur_hi & ~f_mask) | (f_data & f_mask), cur_lo};
            default:  new_word = cur_word;
        endcase
    end

    // Action classification
    always_comb begin
        action = ACT_IDLE;
        unique case (op)
            OP_WRITE:
                action = (lanes != 2'b00) ? ACT_STORE : ACT_IDLE;
            OP_BSET, OP_BCLR, OP_FLDLO, OP_FLDHI:
                action = in_zone ? ACT_STORE : ACT_REJECT;
            default:
                action = ACT_IDLE;
        endcase
    end
endmodule

// File: rtl/sfr_word_store.sv
`timescale 1ns/1ps
module sfr_word_store #(
    parameter int unsigned WORD_W = 16,
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned DEPTH  = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] rdata
);
    logic [WORD_W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
        end else if (we) begin
            mem_q[addr] <= wdata;
        end
    end

    always_comb begin
        rdata = mem_q[addr];
    end

    // R3: an enabled store is visible at the same address one edge later
    a_r3_store_lands: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> (addr != $past(addr)) || (rdata == $past(wdata)));

    // R6/R11: no enable, no change at a held address
    a_r6_hold_without_we: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> (addr != $past(addr)) || (rdata == $past(rdata)));
endmodule

// File: rtl/sfr_bank.sv
`timescale 1ns/1ps
module sfr_bank
    import sfr_bank_pkg::*;
#(
    parameter int unsigned WORD_W    = 16,
    parameter int unsigned ADDR_W    = 8,
    parameter int unsigned TOP_EXCL  = 16,
    localparam int unsigned DEPTH    = 1 << ADDR_W,
    localparam int unsigned ZONE_LO  = DEPTH / 2,
    localparam int unsigned ZONE_HI  = DEPTH - TOP_EXCL - 1,
    localparam int unsigned IDX_W    = $clog2(WORD_W),
    localparam int unsigned BYTE_W   = WORD_W / 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        req_op,
    input  logic [1:0]        req_lanes,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [WORD_W-1:0] req_wdata,
    input  logic [IDX_W-1:0]  req_bit,
    output logic [WORD_W-1:0] rd_data,
    output logic              bit_err
);
    sfr_op_e           op;
    sfr_act_e          action;
    logic              in_zone;
    logic [WORD_W-1:0] cur_word;
    logic [WORD_W-1:0] new_word;
    logic              store_en;

    always_comb begin
        op       = sfr_op_e'(req_op);
        store_en = (action == ACT_STORE);
        bit_err  = (action == ACT_REJECT);
        rd_data  = cur_word;
    end

    sfr_zone_check #(
        .ADDR_W (ADDR_W),
        .ZONE_LO(ZONE_LO),
        .ZONE_HI(ZONE_HI)
    ) zone_i (
        .addr   (req_addr),
        .in_zone(in_zone)
    );

    sfr_op_unit #(
        .WORD_W(WORD_W),
        .IDX_W (IDX_W)
    ) opu_i (
        .op      (op),
        .lanes   (req_lanes),
        .wdata   (req_wdata),
        .bit_idx (req_bit),
        .cur_word(cur_word),
        .in_zone (in_zone),
        .new_word(new_word),
        .action  (action)
    );

    sfr_word_store #(
        .WORD_W(WORD_W),
        .ADDR_W(ADDR_W),
        .DEPTH (DEPTH)
    ) store_i (
        .clk  (clk),
        .rst_n(rst_n),
        .we   (store_en),
        .addr (req_addr),
        .wdata(new_word),
        .rdata(cur_word)
    );

    // ---------------- assertions ----------------
    logic op_is_bit;
    logic lo_write, hi_write;
    always_comb begin
        op_is_bit = (req_op >= 3'd2) && (req_op <= 3'd5);
        lo_write  = (req_op == 3'd1) && (req_lanes == 2'b01);
        hi_write  = (req_op == 3'd1) && (req_lanes == 2'b10);
    end

    a_r4_lo_write_clears_hi: assert property (@(posedge clk) disable iff (!rst_n)
        lo_write |=> (req_addr != $past(req_addr)) ||
                     (rd_data == {{BYTE_W{1'b0}}, $past(req_wdata[BYTE_W-1:0])}));

    a_r5_hi_write_clears_lo: assert property (@(posedge clk) disable iff (!rst_n)
        hi_write |=> (req_addr != $past(req_addr)) ||
                     (rd_data == {$past(req_wdata[WORD_W-1:BYTE_W]), {BYTE_W{1'b0}}}));

    a_r7_bset_one_bit: assert property (@(posedge clk) disable iff (!rst_n)
        (req_op == 3'd2 && !bit_err) |=> (req_addr != $past(req_addr)) ||
            (rd_data == ($past(rd_data) | (WORD_W'(1) << $past(req_bit)))));

    a_r11_err_outside_zone: assert property (@(posedge clk) disable iff (!rst_n)
        (op_is_bit && (req_addr < ADDR_W'(ZONE_LO) || req_addr > ADDR_W'(ZONE_HI))) |-> bit_err);

    a_r11_reject_keeps_word: assert property (@(posedge clk) disable iff (!rst_n)
        bit_err |=> (req_addr != $past(req_addr)) || (rd_data == $past(rd_data)));

    a_r12_err_only_for_bit_ops: assert property (@(posedge clk) disable iff (!rst_n)
        !op_is_bit |-> !bit_err);
endmodule

// File: tb/sfr_bank_tb_top.sv
`timescale 1ns/1ps
module sfr_bank_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  req_op = '0;
    logic [1:0]  req_lanes = '0;
    logic [7:0]  req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic [3:0]  req_bit = '0;
    logic [15:0] rd_data;
    logic        bit_err;

    always #10 clk = ~clk; // 50 MHz

    sfr_bank dut_i (
        .clk(clk), .rst_n(rst_n), .req_op(req_op), .req_lanes(req_lanes),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_bit(req_bit),
        .rd_data(rd_data), .bit_err(bit_err)
    );

    typedef struct {
        string       req;
        bit          is_err;
        logic [15:0] exp;
    } item_t;

    item_t       sb_q [$];
    event        smp_ev;
    int          n_chk = 0;
    int          n_fail = 0;
    logic [15:0] model [256];

    // Monitor: pops expected items and compares against outputs
    initial begin
        forever begin
            @(smp_ev);
            while (sb_q.size() > 0) begin
                item_t it;
                it = sb_q.pop_front();
                n_chk++;
                if (it.is_err) begin
                    if (bit_err !== it.exp[0]) begin
                        n_fail++;
                        $display("FAIL %s bit_err actual=%b expected=%b", it.req, bit_err, it.exp[0]);
                    end
                end else if (rd_data !== it.exp) begin
                    n_fail++;
                    $display("FAIL %s rd_data actual=%h expected=%h", it.req, rd_data, it.exp);
                end
            end
        end
    end

    function automatic bit in_zone(input logic [7:0] a);
        return (a >= 8'd128) && (a <= 8'd239);
    endfunction

    // Driver: applies one request, pushes the expected error flag, updates the model
    task automatic do_op(input logic [2:0] o, input logic [1:0] ln, input logic [7:0] a,
                         input logic [15:0] d, input logic [3:0] idx, input string rq);
        item_t       it;
        logic [15:0] w, m8, d8;
        bit          isbit;
        @(negedge clk);
        req_op = o; req_lanes = ln; req_addr = a; req_wdata = d; req_bit = idx;
        #5;
        isbit = (o >= 3'd2) && (o <= 3'd5);
        it.req = rq; it.is_err = 1'b1;
        it.exp = {15'd0, isbit && !in_zone(a)};
        sb_q.push_back(it);
        -> smp_ev;
        w  = model[a];
        m8 = {8'd0, d[15:8]};
        d8 = {8'd0, d[7:0]};
        if (o == 3'd1) begin
            if (ln == 2'b11)      w = d;
            else if (ln == 2'b01) w = {8'd0, d[7:0]};
            else if (ln == 2'b10) w = {d[15:8], 8'd0};
        end else if (isbit && in_zone(a)) begin
            if (o == 3'd2)      w = w | (16'd1 << idx);
            else if (o == 3'd3) w = w & ~(16'd1 << idx);
            else if (o == 3'd4) w = {w[15:8], (w[7:0] & ~m8[7:0]) | (d8[7:0] & m8[7:0])};
            else                w = {(w[15:8] & ~m8[7:0]) | (d8[7:0] & m8[7:0]), w[7:0]};
        end
        @(posedge clk);
        model[a] = w;
    endtask

    task automatic rd_chk(input logic [7:0] a, input string rq);
        item_t it;
        @(negedge clk);
        req_op = 3'd0; req_addr = a;
        #5;
        it.req = rq; it.is_err = 1'b0; it.exp = model[a];
        sb_q.push_back(it);
        -> smp_ev;
    endtask

    initial begin
        for (int i = 0; i < 256; i++) model[i] = 16'h0000;
        repeat (3) @(posedge clk);
        #3 rst_n = 1'b1;

        rd_chk(8'd0,   "R1");
        rd_chk(8'd128, "R1");
        rd_chk(8'd255, "R1");

        do_op(3'd1, 2'b11, 8'd5, 16'hA5C3, 4'd0, "R12 word write");
        rd_chk(8'd5, "R3");
        rd_chk(8'd6, "R2");
        rd_chk(8'd5, "R2");
        do_op(3'd1, 2'b11, 8'd255, 16'h7E81, 4'd0, "R12");
        rd_chk(8'd255, "R3");

        do_op(3'd1, 2'b01, 8'd5, 16'h1277, 4'd0, "R12");
        rd_chk(8'd5, "R4");
        do_op(3'd1, 2'b10, 8'd5, 16'h9A34, 4'd0, "R12");
        rd_chk(8'd5, "R5");

        do_op(3'd1, 2'b00, 8'd5, 16'hFFFF, 4'd0, "R6 lanes 00");
        rd_chk(8'd5, "R6");
        do_op(3'd6, 2'b11, 8'd5, 16'hFFFF, 4'd0, "R6 reserved 6");
        do_op(3'd7, 2'b11, 8'd5, 16'h0000, 4'd0, "R6 reserved 7");
        rd_chk(8'd5, "R6");

        do_op(3'd1, 2'b11, 8'd130, 16'h0101, 4'd0, "R12");
        do_op(3'd2, 2'b00, 8'd130, 16'h0000, 4'd15, "R12 bset in zone");
        rd_chk(8'd130, "R7");
        do_op(3'd2, 2'b00, 8'd239, 16'h0000, 4'd0, "R12 bset top of zone");
        rd_chk(8'd239, "R7");
        do_op(3'd2, 2'b00, 8'd128, 16'h0000, 4'd9, "R12 bset bottom of zone");
        rd_chk(8'd128, "R7");

        do_op(3'd3, 2'b00, 8'd130, 16'h0000, 4'd8, "R12 bclr");
        rd_chk(8'd130, "R8");

        do_op(3'd1, 2'b11, 8'd140, 16'hF0F0, 4'd0, "R12");
        do_op(3'd4, 2'b00, 8'd140, 16'h3CA5, 4'd0, "R12 field lo");
        rd_chk(8'd140, "R9");
        do_op(3'd5, 2'b00, 8'd140, 16'h0F06, 4'd0, "R12 field hi");
        rd_chk(8'd140, "R10");

        do_op(3'd1, 2'b11, 8'd127, 16'h1111, 4'd0, "R12");
        do_op(3'd2, 2'b00, 8'd127, 16'h0000, 4'd3, "R11 bset below zone");
        rd_chk(8'd127, "R11");
        do_op(3'd1, 2'b11, 8'd240, 16'h2222, 4'd0, "R12");
        do_op(3'd3, 2'b00, 8'd240, 16'h0000, 4'd1, "R11 bclr above zone");
        rd_chk(8'd240, "R11");
        do_op(3'd4, 2'b00, 8'd255, 16'hFF00, 4'd0, "R11 field lo top word");
        do_op(3'd5, 2'b00, 8'd255, 16'hFF00, 4'd0, "R11 field hi top word");
        rd_chk(8'd255, "R11");
        do_op(3'd2, 2'b00, 8'd0, 16'h0000, 4'd7, "R11 bset word 0");
        rd_chk(8'd0, "R11");

        repeat (2) @(posedge clk);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #4000000;
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired before all requirements were checked");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule